// File: doc/BRIEF.md
# DCO Frequency Step Controller

This block nudges the output frequency of a fractional-N PLL up or down in fixed, programmable steps. It keeps a signed running offset, adds it to the base numerator of the feedback divider, and drives the resulting numerator to the divider from a register. Each step request moves the offset by one programmable step word.

Step requests arrive on two paths. The first is a software update strobe that carries a direction bit. The second is a pair of external pulse pins, one for up and one for down. The pins are synchronised, edge-detected and only take effect while pin control is on. One of the pin functions shares a package ball with a status output, so that output is forced low while pin control is on. The mode can only be switched on while the PLL reports lock. Switching it off discards the accumulated offset.

Top module: `dco_step_ctrl`

## Requirements
- R1: While rst_ni is low, num_o is 0. After reset, with the mode off, num_o equals base_num_i one clock later.
- R2: The mode becomes active only on a 0-to-1 transition of mode_en_i that is seen while locked_i is 1. A transition seen while unlocked leaves the mode inactive, even after lock returns, until mode_en_i is cleared and set again.
- R3: While active, a one-cycle sw_upd_i pulse applies one step. sw_dir_i = 0 adds step_i to the offset and sw_dir_i = 1 subtracts it. This holds whether pin_en_i is 0 or 1.
- R4: With pin_en_i = 1, a pulse on inc_pin_i adds one step and a pulse on dec_pin_i subtracts one step. With pin_en_i = 0, the pins have no effect.
- R5: A pin pulse yields exactly one step, however long it stays high. A pulse of 10 or more clock cycles is always captured.
- R6: If up and down requests from any mix of sources fall in the same cycle, no step is applied.
- R7: The offset is a NUM_W+1 bit signed value. It saturates at +(2^NUM_W - 1) and -2^NUM_W and does not wrap.
- R8: num_o is registered and equals base_num_i + offset, clamped to the range 0 to 2^NUM_W - 1.
- R9: Clearing mode_en_i zeroes the offset, so num_o returns to base_num_i. While the mode is inactive, step requests are ignored.
- R10: stat_o follows stat_i when pin_en_i = 0 and is 0 when pin_en_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_en_i | input | 1 | Frequency-step mode enable (register bit) |
| pin_en_i | input | 1 | Pin-control enable (register bit) |
| step_i | input | STEP_W (38) | Step word, unsigned |
| sw_upd_i | input | 1 | Software update strobe, one cycle |
| sw_dir_i | input | 1 | Software direction: 0 up, 1 down |
| inc_pin_i | input | 1 | Asynchronous up-step pulse pin |
| dec_pin_i | input | 1 | Asynchronous down-step pulse pin |
| locked_i | input | 1 | PLL lock indication |
| base_num_i | input | NUM_W (40) | Unmodified divider numerator |
| stat_i | input | 1 | Status signal sharing the down-pin ball |
| stat_o | output | 1 | Status output, low under pin control |
| num_o | output | NUM_W (40) | Adjusted divider numerator, registered |

## Verification
The assertions assume that sw_upd_i is a one-cycle strobe. They also assume that step_i stays constant while a step can land. The stimulus drives every input on the falling clock edge and pulses sw_upd_i for exactly one cycle. It changes step_i and base_num_i only while no request is in flight. Pin pulses are held for at least 10 cycles and are spaced widely, as the pin rate rule requires. One test times a software strobe to land in the same cycle as a synchronised pin edge, to exercise cancellation.

// File: rtl/dco_pkg.sv
package dco_pkg;
  localparam int unsigned NUM_W_DEF  = 40;
  localparam int unsigned STEP_W_DEF = 38;
  localparam int unsigned SYNC_DEF   = 2;

  typedef struct packed {
    logic up;
    logic dn;
  } step_req_t;
endpackage

// File: rtl/dco_pin_edge.sv
module dco_pin_edge #(
  parameter int unsigned NPIN   = 2,
  parameter int unsigned STAGES = dco_pkg::SYNC_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] rise_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [DEPTH-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[DEPTH-2:0], pin_i[p]};
    end
    assign rise_o[p] = sh_q[DEPTH-2] & ~sh_q[DEPTH-1];

    // one request per pulse
    assert_single_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[p] |=> !rise_o[p]);
  end
endmodule

// File: rtl/dco_step_arb.sv
module dco_step_arb (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               active_i,
  input  logic               sw_upd_i,
  input  logic               sw_dir_i,
  input  logic               pin_up_i,
  input  logic               pin_dn_i,
  output dco_pkg::step_req_t req_o
);
  logic up_any, dn_any;

  assign up_any = (sw_upd_i & ~sw_dir_i) | pin_up_i;
  assign dn_any = (sw_upd_i &  sw_dir_i) | pin_dn_i;

  // opposing requests cancel
  assign req_o.up = active_i & up_any & ~dn_any;
  assign req_o.dn = active_i & dn_any & ~up_any;

  assert_req_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_o.up, req_o.dn}));
  assert_idle_no_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !(req_o.up || req_o.dn));
endmodule

// File: rtl/dco_offset_acc.sv
module dco_offset_acc #(
  parameter int unsigned NUM_W  = dco_pkg::NUM_W_DEF,
  parameter int unsigned STEP_W = dco_pkg::STEP_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               active_i,
  input  dco_pkg::step_req_t req_i,
  input  logic [STEP_W-1:0]  step_i,
  input  logic [NUM_W-1:0]   base_i,
  output logic [NUM_W-1:0]   num_o
);
  localparam int unsigned OFS_W = NUM_W + 1;
  localparam logic signed [OFS_W:0] SAT_HI = {2'b00, {(OFS_W-1){1'b1}}};
  localparam logic signed [OFS_W:0] SAT_LO = {2'b11, {(OFS_W-1){1'b0}}};

  logic signed [OFS_W-1:0] ofs_q;
  logic signed [OFS_W:0]   ofs_x, stp_x, sum, raw;
  logic        [NUM_W-1:0] num_q, num_d;

  assign ofs_x = {ofs_q[OFS_W-1], ofs_q};
  assign stp_x = $signed({{(OFS_W+1-STEP_W){1'b0}}, step_i});

  always_comb begin
    sum = ofs_x;
    if (req_i.up)      sum = ofs_x + stp_x;
    else if (req_i.dn) sum = ofs_x - stp_x;
    if (sum > SAT_HI)      sum = SAT_HI;
    else if (sum < SAT_LO) sum = SAT_LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ofs_q <= '0;
    else if (!active_i) ofs_q <= '0;
    else                ofs_q <= sum[OFS_W-1:0];
  end

  assign raw = $signed({2'b00, base_i}) + ofs_x;

  always_comb begin
    if (raw[OFS_W])        num_d = '0;
    else if (raw[OFS_W-1]) num_d = '1;
    else                   num_d = raw[NUM_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) num_q <= '0;
    else         num_q <= num_d;
  end
  assign num_o = num_q;

  assert_hold_no_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !req_i.up && !req_i.dn) |=> $stable(ofs_q));
  assert_sat_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && req_i.up && ofs_x == SAT_HI) |=> ofs_x == SAT_HI);
  assert_sat_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && req_i.dn && ofs_x == SAT_LO) |=> ofs_x == SAT_LO);
  assert_up_grows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && req_i.up) |=> ofs_q >= $past(ofs_q));
  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> ofs_q == '0);
endmodule

// File: rtl/dco_step_ctrl.sv
module dco_step_ctrl #(
  parameter int unsigned NUM_W  = dco_pkg::NUM_W_DEF,
  parameter int unsigned STEP_W = dco_pkg::STEP_W_DEF,
  parameter int unsigned SYNC_N = dco_pkg::SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_en_i,
  input  logic              pin_en_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              sw_upd_i,
  input  logic              sw_dir_i,
  input  logic              inc_pin_i,
  input  logic              dec_pin_i,
  input  logic              locked_i,
  input  logic [NUM_W-1:0]  base_num_i,
  input  logic              stat_i,
  output logic              stat_o,
  output logic [NUM_W-1:0]  num_o
);
  logic               en_d_q, act_q;
  logic [1:0]         rise;
  dco_pkg::step_req_t req;

  // arm only on an enable edge seen while locked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      en_d_q <= mode_en_i;
      if (!mode_en_i)                         act_q <= 1'b0;
      else if (!en_d_q && locked_i)           act_q <= 1'b1;
    end
  end

  dco_pin_edge #(.NPIN(2), .STAGES(SYNC_N)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({dec_pin_i, inc_pin_i}),
    .rise_o (rise)
  );

  dco_step_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (act_q),
    .sw_upd_i (sw_upd_i),
    .sw_dir_i (sw_dir_i),
    .pin_up_i (rise[0] & pin_en_i),
    .pin_dn_i (rise[1] & pin_en_i),
    .req_o    (req)
  );

  dco_offset_acc #(.NUM_W(NUM_W), .STEP_W(STEP_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (act_q),
    .req_i    (req),
    .step_i   (step_i),
    .base_i   (base_num_i),
    .num_o    (num_o)
  );

  assign stat_o = stat_i & ~pin_en_i;

  assert_arm_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(locked_i) && $past(mode_en_i) && !$past(en_d_q));
  assert_pin_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_en_i && !sw_upd_i) |-> !(req.up || req.dn));
  assert_stat_mute_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_en_i |-> !stat_o);
endmodule

// File: tb/tb_dco_step_ctrl.sv
module tb_dco_step_ctrl;
  localparam int NUM_W  = 40;
  localparam int STEP_W = 38;
  localparam logic [NUM_W-1:0]  BASE  = 40'd1000;
  localparam logic [STEP_W-1:0] STEP  = 38'd100;
  localparam logic [NUM_W-1:0]  TOP   = {NUM_W{1'b1}};
  localparam logic [STEP_W-1:0] SMAX  = {STEP_W{1'b1}};
  localparam int NV = 9;
  // 0 sw up, 1 sw dn, 2 pin up, 3 pin dn, 4 both pins, 5 sw up + pin dn same cycle
  localparam logic [2:0]       OP_T  [NV] = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd3, 3'd1};
  localparam logic [NUM_W-1:0] EXP_T [NV] = '{40'd1100, 40'd1200, 40'd1100, 40'd1200, 40'd1100,
                                              40'd1100, 40'd1100, 40'd1000, 40'd900};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mode_en_i = 0, pin_en_i = 0, sw_upd_i = 0, sw_dir_i = 0;
  logic inc_pin_i = 0, dec_pin_i = 0, locked_i = 0, stat_i = 0;
  logic [STEP_W-1:0] step_i = STEP;
  logic [NUM_W-1:0]  base_num_i = BASE;
  logic              stat_o;
  logic [NUM_W-1:0]  num_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  dco_step_ctrl dut (.*);

  task automatic chk(input string req, input logic [NUM_W-1:0] act, input logic [NUM_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic sw_step(input logic dir);
    @(negedge clk_i); sw_dir_i = dir; sw_upd_i = 1;
    @(negedge clk_i); sw_upd_i = 0;
    idle(4);
  endtask

  task automatic pin_pulse(input logic up, input logic dn, input int w);
    @(negedge clk_i); inc_pin_i = up; dec_pin_i = dn;
    idle(w);
    inc_pin_i = 0; dec_pin_i = 0;
    idle(6);
  endtask

  task automatic rearm();
    @(negedge clk_i); mode_en_i = 0;
    idle(2); mode_en_i = 1;
    idle(3);
  endtask

  task automatic run_op(input logic [2:0] op);
    case (op)
      3'd0: sw_step(1'b0);
      3'd1: sw_step(1'b1);
      3'd2: pin_pulse(1, 0, 12);
      3'd3: pin_pulse(0, 1, 12);
      3'd4: pin_pulse(1, 1, 12);
      default: begin
        // pin edge reaches the request stage two edges after the pin is set
        @(negedge clk_i); dec_pin_i = 1;
        idle(2); sw_dir_i = 0; sw_upd_i = 1;
        idle(1); sw_upd_i = 0;
        idle(10); dec_pin_i = 0;
        idle(6);
      end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 reset", num_o, 0);
    rst_ni = 1;
    idle(3);
    chk("R1 base pass", num_o, BASE);

    // R2: enable edge while unlocked does nothing
    mode_en_i = 1; idle(3);
    locked_i = 1;  idle(3);
    sw_step(1'b0);
    chk("R2 unlocked arm", num_o, BASE);
    rearm();
    sw_step(1'b0);
    chk("R2 locked arm", num_o, BASE + 100);

    // R3 with pin control off, R4 pins ignored, R10 status pass
    sw_step(1'b1);
    chk("R3 sw dn pin off", num_o, BASE);
    stat_i = 1; idle(1);
    chk("R10 status pass", {39'd0, stat_o}, 1);
    pin_pulse(1, 0, 12);
    chk("R4 pin ignored", num_o, BASE);
    pin_en_i = 1; idle(1);
    chk("R10 status muted", {39'd0, stat_o}, 0);

    // table walk: R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      run_op(OP_T[i]);
      chk($sformatf("R3/R4/R6 vec %0d", i), num_o, EXP_T[i]);
    end

    // R5 long pulse gives one step
    pin_pulse(1, 0, 60);
    chk("R5 long pulse", num_o, 40'd1000);

    // R9 disable clears offset, steps ignored while off
    @(negedge clk_i); mode_en_i = 0; idle(3);
    chk("R9 clear", num_o, BASE);
    sw_step(1'b0);
    chk("R9 ignored", num_o, BASE);

    // R7 saturation: 5 up then 4 down of max step from 0
    base_num_i = 0; step_i = SMAX;
    rearm();
    for (int k = 0; k < 5; k++) sw_step(1'b0);
    chk("R8 clamp high", num_o, TOP);
    for (int k = 0; k < 4; k++) sw_step(1'b1);
    chk("R7 saturate", num_o, 40'd3);

    // R8 clamp at both ends
    step_i = STEP; base_num_i = TOP - 40'd49;
    rearm();
    sw_step(1'b0);
    chk("R8 clamp top", num_o, TOP);
    base_num_i = 40'd20; idle(2);
    chk("R8 base track", num_o, 40'd120);
    sw_step(1'b1); sw_step(1'b1);
    chk("R8 clamp zero", num_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule